// File: doc/BRIEF.md
# Six-Lane Lockstep SPI Master

This block is an SPI master that talks to six converters at the same time. All six share one serial clock and one active-low select. Each converter has its own data-out line and its own data-in line. A transaction begins when a request carrying six 16-bit configuration words is accepted. The block drives every configuration word out on its own lane, one bit per serial clock. It then runs the same number of serial clocks again and collects a 16-bit result word from every lane. It pulses `done` when the six result words are ready on `result_word`.

The serial clock comes from the system clock through a bit-period setting. That setting is latched when a request is accepted. Every bit period has an equal high half and low half. The request side is a valid/ready handshake. `cfg_ready` is high only while the block is idle, and a request is taken on a cycle where both `cfg_valid` and `cfg_ready` are high. While a transaction runs, `cfg_ready` stays low, and `cfg_valid` together with `cfg_word` have no effect. The result side has no back-pressure. `done` is a single-cycle strobe, and `result_word` keeps its value until the end of the next transaction.

Lane i uses bits [16*i+15 : 16*i] of `cfg_word` and of `result_word`. It uses bit i of `mosi` and of `miso`. Within each lane, bit 15 is the first bit on the wire.

Top module: `lockstep_spi_master`

## Requirements
- R1: `cfg_ready` is 1 exactly when no transaction is running, and `cs_n` is high then. A transaction starts on a clock edge where `cfg_valid` and `cfg_ready` are both 1. A `cfg_valid` raised during a transaction changes neither the data driven nor the data captured.
- R2: The effective bit period P is taken from `period_cfg` at acceptance. An odd value is rounded down to the next even number, and any value below 4 becomes 4. The serial clock is high for P/2 system clocks and low for P/2 system clocks, and it rises P/2 clocks into each bit period.
- R3: In the write phase, each lane sends its 16-bit configuration word, bit 15 first, one bit per serial clock period.
- R4: In the read phase, all six `miso` lines are captured together once per bit. The capture happens at system clock P-1 of the bit period, one clock before the falling edge. The bits are assembled bit 15 first into that lane's result word.
- R5: The serial clock idles low. `cs_n` goes low one bit period before the first write bit and rises one bit period after the last read bit, so it is low for 34·P system clocks in total.
- R6: A `mosi` line never changes while the serial clock is high, and never in the system clock right after a falling edge.
- R7: `result_word` changes only at the end of a read phase, and it holds its value while the next transaction runs.
- R8: `done` is high for exactly one system clock per transaction. It appears 33·P system clocks after `cs_n` falls, in the same cycle the new `result_word` becomes visible.
- R9: The read phase runs as many serial clock periods as the write phase, so each transaction has exactly 32 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | 8 | Requested bit period in system clocks, latched at acceptance |
| cfg_valid | input | 1 | Request valid |
| cfg_ready | output | 1 | Block idle, able to accept a request |
| cfg_word | input | 96 | Six packed 16-bit configuration words |
| sclk | output | 1 | Shared serial clock, idles low |
| cs_n | output | 1 | Active-low select |
| mosi | output | 6 | Per-lane serial data out |
| miso | input | 6 | Per-lane serial data in |
| done | output | 1 | One-cycle end-of-transaction strobe |
| result_word | output | 96 | Six packed 16-bit result words |

## Verification
The bench drives periods at the lower limit and periods that are odd or below the floor. A design that skips the rounding or the floor would give a transaction that takes the wrong number of cycles. It would also give a serial clock whose high and low times differ. The bench's model of the converter changes `miso` at the rising edge, then corrupts it right after the intended capture instant, so a design that samples at the falling edge reads back inverted bits. Words with a single set bit or a single cleared bit at either end show any reversal or off-by-one in the bit order. A request raised while the block is busy, carrying inverted data, would show up on the wire or in the results if the handshake did not block it.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_WRITE,
    PH_READ,
    PH_TRAIL
  } phase_e;
endpackage

// File: rtl/lsm_bit_timer.sv
module lsm_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             toggle_en,
  input  logic [DIV_W-1:0] period,
  output logic [DIV_W-1:0] cnt,
  output logic             at_last,
  output logic             at_samp,
  output logic             sclk
);
  logic [DIV_W-1:0] half;

  assign half    = period >> 1;
  assign at_last = (cnt == period - DIV_W'(1));
  assign at_samp = (cnt == period - DIV_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= at_last ? '0 : cnt + DIV_W'(1);
      if (at_last || !toggle_en)
        sclk <= 1'b0;
      else if (cnt == half - DIV_W'(1))
        sclk <= 1'b1;
    end
  end

  // R2: the clock rises exactly half a period into the bit
  a_r2_rise_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (cnt == half));
  // R2: the clock falls only at a bit boundary
  a_r2_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (cnt == '0));
endmodule

// File: rtl/lsm_lane.sv
module lsm_lane #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              tx_shift,
  input  logic              rx_shift,
  input  logic              rx_bit,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_next
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;

  assign mosi_o  = tx_q[WORD_W-1];
  assign rx_next = {rx_q[WORD_W-2:0], rx_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else begin
      if (tx_shift) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (rx_shift) rx_q <= rx_next;
    end
  end

  // R3: the first wire bit is the word's top bit
  a_r3_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mosi_o == $past(load_word[WORD_W-1])));
endmodule

// File: rtl/lockstep_spi_master.sv
module lockstep_spi_master
  import lsm_pkg::*;
#(
  parameter int LANES  = 6,
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        period_cfg,
  input  logic                    cfg_valid,
  output logic                    cfg_ready,
  input  logic [LANES*WORD_W-1:0] cfg_word,
  output logic                    sclk,
  output logic                    cs_n,
  output logic [LANES-1:0]        mosi,
  input  logic [LANES-1:0]        miso,
  output logic                    done,
  output logic [LANES*WORD_W-1:0] result_word
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int BUS_W = LANES * WORD_W;
  localparam logic [DIV_W-1:0] MIN_P = DIV_W'(4);

  phase_e             state;
  logic [BIT_W-1:0]   bit_idx;
  logic [DIV_W-1:0]   period_q;
  logic [DIV_W-1:0]   eff_p;
  logic [DIV_W-1:0]   cnt;
  logic               at_last, at_samp;
  logic [LANES-1:0]   snap_q;
  logic [BUS_W-1:0]   result_q;
  logic [BUS_W-1:0]   rx_all;
  logic               done_q;
  logic               accept, bit_last, tx_shift, snap_en, rx_shift, finish_rd;

  assign eff_p     = (period_cfg < MIN_P) ? MIN_P : {period_cfg[DIV_W-1:1], 1'b0};
  assign cfg_ready = (state == PH_IDLE);
  assign cs_n      = (state == PH_IDLE);
  assign accept    = cfg_valid && cfg_ready;
  assign bit_last  = (bit_idx == BIT_W'(WORD_W-1));
  assign tx_shift  = (cnt == '0) &&
                     (((state == PH_WRITE) && (bit_idx != '0)) ||
                      ((state == PH_READ)  && (bit_idx == '0)));
  assign snap_en   = (state == PH_READ) && at_samp;
  assign rx_shift  = (state == PH_READ) && at_last;
  assign finish_rd = rx_shift && bit_last;
  assign done        = done_q;
  assign result_word = result_q;

  lsm_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state != PH_IDLE),
    .toggle_en ((state == PH_WRITE) || (state == PH_READ)),
    .period    (period_q),
    .cnt       (cnt),
    .at_last   (at_last),
    .at_samp   (at_samp),
    .sclk      (sclk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsm_lane #(.WORD_W(WORD_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (cfg_word[g*WORD_W +: WORD_W]),
      .tx_shift  (tx_shift),
      .rx_shift  (rx_shift),
      .rx_bit    (snap_q[g]),
      .mosi_o    (mosi[g]),
      .rx_next   (rx_all[g*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      bit_idx  <= '0;
      period_q <= MIN_P;
      snap_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (snap_en) snap_q <= miso;
      unique case (state)
        PH_IDLE: if (accept) begin
          period_q <= eff_p;
          bit_idx  <= '0;
          state    <= PH_LEAD;
        end
        PH_LEAD: if (at_last) state <= PH_WRITE;
        PH_WRITE: if (at_last) begin
          bit_idx <= bit_last ? '0 : bit_idx + BIT_W'(1);
          if (bit_last) state <= PH_READ;
        end
        PH_READ: if (at_last) begin
          bit_idx <= bit_last ? '0 : bit_idx + BIT_W'(1);
          if (finish_rd) begin
            result_q <= rx_all;
            done_q   <= 1'b1;
            state    <= PH_TRAIL;
          end
        end
        PH_TRAIL: if (at_last) state <= PH_IDLE;
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R1: no request is taken while the select is active
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !cfg_ready);
  // R4: capture happens while the serial clock is high
  a_r4_snap_high: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |-> sclk);
  // R5: serial clock idles low
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R6: data held through the high half
  a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  // R6: data held for one clock after the falling edge
  a_r6_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(mosi));
  // R7: results move only together with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result_word));
  // R8: done is a single-cycle strobe
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/lockstep_spi_master_tb.sv
module lockstep_spi_master_tb;
  localparam int LANES = 6;
  localparam int W     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] period_cfg = 8'd20;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [LANES*W-1:0] cfg_word = '0;
  logic sclk, cs_n, done;
  logic [LANES-1:0] mosi;
  logic [LANES-1:0] miso_r = '0;
  logic [LANES*W-1:0] result_word;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [W-1:0] cfg_a [LANES];
  logic [W-1:0] rsp_a [LANES];
  logic [W-1:0] prev_a[LANES];

  // independent serial-clock shape monitor
  int exp_half = 10;
  int hi_run = 0, lo_run = 0, shape_bad = 0, r6_bad = 0, rises = 0;
  bit seen_hi = 0;
  logic [LANES-1:0] prev_mosi = '0;
  logic prev_sclk = 1'b0;

  always #2 clk = ~clk;

  lockstep_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_word(cfg_word),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso_r),
    .done(done), .result_word(result_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_p(input int p);
    if (p < 4) return 4;
    return p & ~1;
  endfunction

  always @(posedge sclk) rises++;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (sclk) begin
        if (!prev_sclk && seen_hi && lo_run != exp_half) shape_bad++;
        hi_run++;
        seen_hi = 1;
        lo_run = 0;
      end else begin
        if (prev_sclk && hi_run != exp_half) shape_bad++;
        hi_run = 0;
        if (!cs_n) lo_run++;
        else begin lo_run = 0; seen_hi = 0; end
      end
      if (mosi != prev_mosi && (sclk || prev_sclk)) r6_bad++;
      prev_mosi = mosi;
      prev_sclk = sclk;
    end
  end

  task automatic run_txn(input int pcfg, input bit poke);
    int p = eff_p(pcfg);
    int r0, s0, b0;
    logic [W-1:0] got[LANES];
    int td = -1, t = 1, dcnt = 0;
    @(negedge clk);
    chk(cfg_ready == 1'b1, "R1", "ready when idle", cfg_ready, 1);
    exp_half = p / 2;
    r0 = rises; s0 = shape_bad; b0 = r6_bad;
    period_cfg = 8'(pcfg);
    for (int l = 0; l < LANES; l++) cfg_word[l*W +: W] = cfg_a[l];
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(cs_n == 1'b0, "R5", "select low after accept", cs_n, 0);
    fork
      begin
        for (int n = 0; n < 32; n++) begin
          @(posedge sclk);
          if (n < 16) begin
            for (int l = 0; l < LANES; l++) got[l][15-n] = mosi[l];
          end else begin
            for (int l = 0; l < LANES; l++) miso_r[l] <= rsp_a[l][31-n];
            repeat (p/2 - 1) @(posedge clk);
            for (int l = 0; l < LANES; l++) miso_r[l] <= ~rsp_a[l][31-n];
          end
        end
      end
      begin
        while (cs_n == 1'b0 && t < 20000) begin
          if (done) begin dcnt++; if (td < 0) td = t; end
          if (t == 17*p) begin
            for (int l = 0; l < LANES; l++)
              chk(result_word[l*W +: W] == prev_a[l], "R7", "result held mid-run",
                  result_word[l*W +: W], prev_a[l]);
          end
          @(negedge clk);
          t++;
        end
      end
      begin
        if (poke) begin
          repeat (3*p) @(negedge clk);
          cfg_valid = 1'b1;
          cfg_word = ~cfg_word;
          chk(cfg_ready == 1'b0, "R1", "not ready while busy", cfg_ready, 0);
          repeat (5) @(negedge clk);
          cfg_valid = 1'b0;
        end
      end
    join
    chk(td == 33*p + 1, "R8", "done timing", td, 33*p + 1);
    chk(dcnt == 1, "R8", "done width", dcnt, 1);
    chk(t == 34*p + 1, "R5", "select low length", t, 34*p + 1);
    chk(rises - r0 == 32, "R9", "rising edge count", rises - r0, 32);
    chk(shape_bad == s0, "R2", "clock half lengths", shape_bad - s0, 0);
    chk(r6_bad == b0, "R6", "data change timing", r6_bad - b0, 0);
    for (int l = 0; l < LANES; l++) begin
      chk(got[l] == cfg_a[l], "R3", $sformatf("lane %0d wire word", l), got[l], cfg_a[l]);
      chk(result_word[l*W +: W] == rsp_a[l], "R4", $sformatf("lane %0d result", l),
          result_word[l*W +: W], rsp_a[l]);
    end
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && cfg_ready == 1'b1, "R5", "idle after run", {sclk, cfg_ready}, 2'b01);
    for (int l = 0; l < LANES; l++) begin
      chk(result_word[l*W +: W] == rsp_a[l], "R7", "result held after run",
          result_word[l*W +: W], rsp_a[l]);
      prev_a[l] = rsp_a[l];
    end
  endtask

  initial begin
    fork
      begin
        while (cycles < 150000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    join_none
    void'($urandom(32'd4242));
    for (int l = 0; l < LANES; l++) prev_a[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && done == 0 && cfg_ready == 1, "R5", "reset state",
        {cs_n, sclk, done, cfg_ready}, 4'b1001);
    chk(mosi == '0 && result_word == '0, "R7", "reset outputs", mosi, 0);

    for (int l = 0; l < LANES; l++) begin
      cfg_a[l] = 16'h8000 >> l;
      rsp_a[l] = 16'h0001 << l;
    end
    run_txn(20, 1'b0);
    for (int l = 0; l < LANES; l++) begin
      cfg_a[l] = ~(16'h0001 << l);
      rsp_a[l] = ~(16'h8000 >> l);
    end
    run_txn(18, 1'b1);
    for (int l = 0; l < LANES; l++) begin
      cfg_a[l] = l[0] ? 16'hFFFF : 16'h0000;
      rsp_a[l] = l[0] ? 16'h0000 : 16'hFFFF;
    end
    run_txn(4, 1'b0);
    for (int l = 0; l < LANES; l++) begin
      cfg_a[l] = 16'hA5C3 ^ 16'(l);
      rsp_a[l] = 16'h3C5A + 16'(l);
    end
    run_txn(7, 1'b1);
    run_txn(1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      for (int l = 0; l < LANES; l++) begin
        cfg_a[l] = 16'($urandom);
        rsp_a[l] = 16'($urandom);
      end
      run_txn(int'($urandom_range(25, 2)), k[0]);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule